// File: doc/BRIEF.md
# Receive Task Controller

A command-driven receive sequencer. A host places a 3-bit task code on the command port and pulses a write strobe. The controller then runs that one task against the incoming serial bit stream. It signals completion by setting its buffer-free and interrupt status bits, and the host may then collect any result and issue the next task. Only one task runs at a time. A command that arrives while a task is still running is dropped, and a sticky error flag records it.

The tasks are as follows. The null task does nothing. Two frame-sync searches, one tolerant and one strict, correlate the last 16 received bits against a programmable sync pattern. A raw byte read shifts exactly eight received bits into byte 0 of a small data buffer. A sync-pattern load copies two bytes, which the host must have written into the data buffer beforehand, into the correlator's pattern. Every non-null completion emits a one-cycle pulse that reinitialises an external CRC checker.

The state machine has four states. ST_IDLE waits for a command. ST_SEARCH runs both search variants, and a register holds the error tolerance. ST_BYTE assembles a raw byte. ST_LOAD copies the pattern in a single cycle. The transitions are: IDLE→SEARCH on an accepted code 1 or 2; IDLE→BYTE on code 3; IDLE→LOAD on code 4; IDLE→IDLE on code 0 or 5–7, which complete at once; SEARCH→IDLE on a correlator hit; BYTE→IDLE on the eighth bit; LOAD→IDLE unconditionally after one cycle.

Top module: `rx_task_ctrl`

## Requirements
- R1: After reset, bfree=1, irq=0, cmd_err=0, crc_init=0, sync_pat equals the SYNC_INIT parameter (default 16'h5E3C), and buf_q=0.
- R2: The host issues a task by pulsing cmd_wr with cmd_code: 0 = null, 1 = tolerant search, 2 = strict search, 3 = read byte, 4 = load sync. Codes 5–7 behave as null. A command is accepted only while bfree=1. For codes 1–4, bfree reads 0 from the cycle after the write until the task completes.
- R3: On the clock edge where a task completes, bfree and irq both become 1. A stat_rd pulse clears irq on the next edge, unless a completion happens on that same edge.
- R4: The read-byte task takes the first 8 cycles with rx_vld=1 after acceptance. The first of these bits lands in bit 7 of buffer byte 0 (buf_q[15:8]), and the last in bit 0. The task completes on the edge of the 8th bit.
- R5: The load-sync task sets sync_pat to {byte 0, byte 1} (buf_q as written by the host), with sync_pat[15] compared against the earliest bit of a window. It completes one edge after acceptance and does not start a search: later received bits leave bfree and irq unchanged.
- R6: The tolerant search completes on the valid bit whose window of the last 16 bits received since the task started differs from sync_pat in at most 1 position. Fewer than 16 bits never complete it.
- R7: The strict search completes only on an exact 16-bit match. A window with one differing bit does not complete it.
- R8: crc_init is a one-cycle pulse in the cycle after each completion of codes 1–4, coincident with bfree rising. Null and undefined codes never raise it.
- R9: A null or undefined code sets irq on the next edge while bfree stays 1.
- R10: cmd_wr while bfree=0 is ignored (the running task continues unchanged) and sets cmd_err, which holds until reset.
- R11: Bits received while idle have no effect: they do not enter a later byte read or search window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 3 | Task code |
| stat_rd | input | 1 | Status read strobe, clears irq |
| buf_wr | input | 1 | Host data buffer write strobe |
| buf_sel | input | 1 | Buffer byte select (0 or 1) |
| buf_wdata | input | 8 | Host write data |
| rx_vld | input | 1 | Received bit valid |
| rx_bit | input | 1 | Received bit |
| buf_q | output | 16 | Data buffer, byte 0 in [15:8] |
| sync_pat | output | 16 | Current sync pattern |
| bfree | output | 1 | Buffer free / ready for next task |
| irq | output | 1 | Task complete interrupt |
| cmd_err | output | 1 | Sticky command-while-busy flag |
| crc_init | output | 1 | CRC reinitialise pulse |

## Verification
A wrong state or tolerance register shows up on bfree at the exact bit where the reference window model expects a match, or fails to show up there. The error is therefore visible within one received bit of the fault. A corrupted byte assembler shows in buf_q[15:8] on the edge of the eighth bit. A stray or missing CRC pulse is seen in the cycle after completion. A command that leaks through while busy shows as a shifted completion point on the next bfree check.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [2:0] {
        TK_NULL   = 3'd0,
        TK_SRCH1  = 3'd1,
        TK_SRCH0  = 3'd2,
        TK_RDBYTE = 3'd3,
        TK_LDSYNC = 3'd4
    } task_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_BYTE,
        ST_LOAD
    } rtc_state_e;
endpackage

// File: rtl/sync_corr.sv
module sync_corr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    input  logic         tol,
    input  logic [W-1:0] pat,
    output logic         hit
);
    localparam int FILL_W = $clog2(W + 1);

    logic [W-1:0]      win;
    logic [W-1:0]      win_nx;
    logic [FILL_W-1:0] fill;
    logic              full_nx;
    int                errs;

    assign win_nx  = {win[W-2:0], bit_in};
    assign full_nx = (fill >= FILL_W'(W - 1));
    assign errs    = $countones(win_nx ^ pat);
    assign hit     = en && full_nx && (errs <= int'(tol));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win  <= '0;
            fill <= '0;
        end else if (en) begin
            win <= win_nx;
            if (fill < FILL_W'(W)) fill <= fill + 1'b1;
        end
    end

    p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(W));
endmodule

// File: rtl/rx_byte_asm.sv
module rx_byte_asm #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    output logic         done,
    output logic [W-1:0] val
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    assign val  = {sh[W-2:0], bit_in};
    assign done = en && (cnt == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh  <= '0;
            cnt <= '0;
        end else if (en) begin
            sh  <= val;
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == CW'(W - 1)) |=> (cnt == '0));
endmodule

// File: rtl/rx_task_ctrl.sv
module rx_task_ctrl
    import rtc_pkg::*;
#(
    parameter int          SYNC_W    = 16,
    parameter logic [15:0] SYNC_INIT = 16'h5E3C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr,
    input  logic [2:0]          cmd_code,
    input  logic                stat_rd,
    input  logic                buf_wr,
    input  logic                buf_sel,
    input  logic [7:0]          buf_wdata,
    input  logic                rx_vld,
    input  logic                rx_bit,
    output logic [SYNC_W-1:0]   buf_q,
    output logic [SYNC_W-1:0]   sync_pat,
    output logic                bfree,
    output logic                irq,
    output logic                cmd_err,
    output logic                crc_init
);
    localparam int NB = SYNC_W / 8;

    rtc_state_e state, state_nx;
    logic       tol_q, tol_nx;
    logic [7:0] dbuf [NB];
    logic       accept, start, null_done, done;
    logic       hit, byte_done;
    logic [7:0] byte_val;

    assign accept    = cmd_wr && bfree;
    assign start     = accept && (state_nx != ST_IDLE);
    assign null_done = accept && (state_nx == ST_IDLE);

    sync_corr #(.W(SYNC_W)) u_corr (
        .clk(clk), .rst_n(rst_n), .clr(start),
        .en(state == ST_SEARCH && rx_vld), .bit_in(rx_bit),
        .tol(tol_q), .pat(sync_pat), .hit(hit)
    );

    rx_byte_asm #(.W(8)) u_byte (
        .clk(clk), .rst_n(rst_n), .clr(start),
        .en(state == ST_BYTE && rx_vld), .bit_in(rx_bit),
        .done(byte_done), .val(byte_val)
    );

    always_comb begin
        state_nx = state;
        tol_nx   = tol_q;
        done     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    unique case (cmd_code)
                        TK_SRCH1:  begin state_nx = ST_SEARCH; tol_nx = 1'b1; end
                        TK_SRCH0:  begin state_nx = ST_SEARCH; tol_nx = 1'b0; end
                        TK_RDBYTE: state_nx = ST_BYTE;
                        TK_LDSYNC: state_nx = ST_LOAD;
                        default:   state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_SEARCH: if (hit) begin state_nx = ST_IDLE; done = 1'b1; end
            ST_BYTE:   if (byte_done) begin state_nx = ST_IDLE; done = 1'b1; end
            ST_LOAD:   begin state_nx = ST_IDLE; done = 1'b1; end
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tol_q <= 1'b0;
        end else begin
            state <= state_nx;
            tol_q <= tol_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bfree    <= 1'b1;
            irq      <= 1'b0;
            cmd_err  <= 1'b0;
            crc_init <= 1'b0;
            sync_pat <= SYNC_INIT[SYNC_W-1:0];
            for (int i = 0; i < NB; i++) dbuf[i] <= '0;
        end else begin
            crc_init <= done;
            if (cmd_wr && !bfree) cmd_err <= 1'b1;
            if (start)     bfree <= 1'b0;
            else if (done) bfree <= 1'b1;
            if (done || null_done) irq <= 1'b1;
            else if (stat_rd)      irq <= 1'b0;
            if (state == ST_LOAD) sync_pat <= buf_q;
            for (int i = 0; i < NB; i++)
                if (buf_wr && (int'(buf_sel) == i)) dbuf[i] <= buf_wdata;
            if (state == ST_BYTE && byte_done) dbuf[0] <= byte_val;
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_flat
        assign buf_q[(NB-1-g)*8 +: 8] = dbuf[g];
    end

    p_done_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bfree) |-> irq);
    p_crc_only_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        crc_init |-> $rose(bfree));
    p_crc_every_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bfree) |-> crc_init);
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);
    p_busy_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !bfree) |=> (cmd_err && !bfree || state == ST_IDLE));
    p_load_pat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (sync_pat == $past(buf_q) && bfree));
    p_null_keeps_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        null_done |=> (bfree && irq && !crc_init));
endmodule

// File: tb/tb_rx_task_ctrl.sv
module tb_rx_task_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic        stat_rd = 1'b0;
    logic        buf_wr = 1'b0;
    logic        buf_sel = 1'b0;
    logic [7:0]  buf_wdata = 8'd0;
    logic        rx_vld = 1'b0;
    logic        rx_bit = 1'b0;
    logic [15:0] buf_q, sync_pat;
    logic        bfree, irq, cmd_err, crc_init;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rx_task_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .stat_rd(stat_rd), .buf_wr(buf_wr), .buf_sel(buf_sel),
        .buf_wdata(buf_wdata), .rx_vld(rx_vld), .rx_bit(rx_bit),
        .buf_q(buf_q), .sync_pat(sync_pat), .bfree(bfree), .irq(irq),
        .cmd_err(cmd_err), .crc_init(crc_init)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [2:0] c);
        @(negedge clk); cmd_wr = 1'b1; cmd_code = c;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic send_bit(logic b);
        @(negedge clk); rx_vld = 1'b1; rx_bit = b;
        @(negedge clk); rx_vld = 1'b0;
    endtask

    task automatic read_stat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic host_wr(logic s, logic [7:0] d);
        @(negedge clk); buf_wr = 1'b1; buf_sel = s; buf_wdata = d;
        @(negedge clk); buf_wr = 1'b0;
    endtask

    function automatic bit exp_match(logic [15:0] w, logic [15:0] p, int cnt, bit tol);
        return (cnt >= 16) && ($countones(w ^ p) <= (tol ? 1 : 0));
    endfunction

    task automatic read_byte_check(logic [7:0] v, string tag);
        issue(3'd3);
        chk({tag, " R2 busy"}, 32'(bfree), 0);
        for (int i = 7; i >= 0; i--) begin
            send_bit(v[i]);
            if (i > 0) chk({tag, " R4 not yet"}, 32'(bfree), 0);
        end
        chk({tag, " R4 byte"}, 32'(buf_q[15:8]), 32'(v));
        chk({tag, " R3 flags"}, 32'({bfree, irq}), 32'd3);
        chk({tag, " R8 crc"}, 32'(crc_init), 1);
        read_stat();
        chk({tag, " R3 irq clr"}, 32'(irq), 0);
    endtask

    task automatic load_sync(logic [15:0] p);
        host_wr(1'b0, p[15:8]);
        host_wr(1'b1, p[7:0]);
        issue(3'd4);
        chk("R2 load busy", 32'(bfree), 0);
        @(negedge clk);
        chk("R5 pattern", 32'(sync_pat), 32'(p));
        chk("R5 done", 32'({bfree, irq, crc_init}), 32'd7);
        read_stat();
    endtask

    task automatic search_run(logic [15:0] p, bit tol, logic [15:0] emask, string tag);
        logic [15:0] w = '0;
        int cnt = 0;
        bit fin = 0;
        logic [31:0] stream = {p ^ emask, p};
        issue(tol ? 3'd1 : 3'd2);
        for (int i = 31; i >= 0 && !fin; i--) begin
            send_bit(stream[i]);
            w = {w[14:0], stream[i]};
            cnt++;
            fin = exp_match(w, p, cnt, tol);
            chk({tag, tol ? " R6 search" : " R7 search"}, 32'(bfree), 32'(fin));
            if (fin) chk({tag, " R8 crc"}, 32'(crc_init), 1);
        end
        read_stat();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd909));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", 32'({bfree, irq, cmd_err, crc_init}), 32'b1000);
        chk("R1 pattern", 32'(sync_pat), 32'h5E3C);
        chk("R1 buffer", 32'(buf_q), 0);

        issue(3'd0);
        chk("R9 null flags", 32'({bfree, irq, crc_init}), 32'b110);
        read_stat();
        chk("R3 irq clear", 32'(irq), 0);
        issue(3'd6);
        chk("R9 undefined code", 32'({bfree, irq, crc_init}), 32'b110);
        read_stat();

        for (int i = 0; i < 5; i++) send_bit(1'b1);
        chk("R11 idle bits", 32'({bfree, irq, buf_q[15:8]}), 32'h200);
        read_byte_check(8'h01, "R11 after idle");
        read_byte_check(8'h80, "dir");
        for (int k = 0; k < 20; k++) read_byte_check(8'($urandom), "rnd");

        load_sync(16'hA5C3);
        for (int i = 0; i < 20; i++) send_bit(1'($urandom));
        chk("R5 no search", 32'({bfree, irq}), 32'b10);

        search_run(16'hA5C3, 1'b1, 16'h0000, "dir tol exact");
        search_run(16'hA5C3, 1'b1, 16'h0100, "dir tol one");
        search_run(16'hA5C3, 1'b0, 16'h0100, "dir strict one");
        search_run(16'hA5C3, 1'b0, 16'h0000, "dir strict exact");
        for (int k = 0; k < 30; k++) begin
            logic [15:0] p = 16'($urandom);
            logic [15:0] m = '0;
            int ne = $urandom_range(0, 2);
            for (int e = 0; e < ne; e++) m[$urandom_range(0, 15)] = 1'b1;
            load_sync(p);
            search_run(p, 1'($urandom), m, "rnd");
        end

        issue(3'd3);
        issue(3'd1);
        chk("R10 err set", 32'({cmd_err, bfree}), 32'b10);
        for (int i = 7; i >= 0; i--) send_bit(1'(8'h6B >> i));
        chk("R10 task kept", 32'({bfree, buf_q[15:8]}), 32'h16B);
        read_stat();
        issue(3'd0);
        chk("R10 sticky", 32'(cmd_err), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule